// File: doc/BRIEF.md
# Endian-Mode Address Munging Unit

This unit sits between a load/store pipeline and a 64-bit big-endian data bus. It lets software run with a little-endian view of memory without swapping data lanes. In little-endian mode it exclusive-ORs the three low bits of the effective address with a constant that depends on the operand size. The bus and its lane numbering stay big-endian throughout. Page-table and hash-table walk accesses are exempt from this and always go out in big-endian form.

Each request carries an effective address, an operand size, a walk flag and write data. The unit works out the bus address and the byte enables from these. It places the write data on the selected lanes and takes read data back from the same lanes, right-justified. Read data on `bus_rdata` is expected in the same cycle as the request. A mode register selects big- or little-endian operation and can be rewritten at any clock edge. A static configuration input turns on a full 8-byte swap of every beat entering or leaving the unit. Requests that are not naturally aligned raise an error flag and are kept off the bus.

Top module: `endian_munge_unit`

## Requirements
- R1: After reset the unit is in big-endian mode, so `bus_addr` equals `req_addr` for every operand size.
- R2: In little-endian mode, for accesses that are not walks, `bus_addr[2:0]` is `req_addr[2:0]` XOR a constant: 3'b111 for a byte (size code 0), 3'b110 for a halfword (code 1), 3'b100 for a word (code 2) and 3'b000 for a doubleword (code 3). Address bits above bit 2 are always passed unchanged.
- R3: A high `mode_set` at a rising clock edge loads `mode_le_in` into the mode register. The new mode applies to requests presented after that edge. While `mode_set` is low the mode holds.
- R4: When `req_walk` is 1, the request is never munged, whatever the mode.
- R5: A vector request (size code 4, or any code of 3 or more) uses 8 lanes, needs 8-byte alignment and is munged with the constant 3'b000.
- R6: `bus_be[j]` enables `bus_wdata[8j+7:8j]`. Lane o (o = 0 is bits 63:56) maps to `bus_be[7-o]`. A valid request of n bytes at munged offset o enables exactly lanes o through o+n-1.
- R7: The low n bytes of `req_wdata` are placed on the enabled lanes, with the operand's most significant byte in lane o. All other lanes carry zero.
- R8: `rd_data` holds the enabled lanes of the read beat, right-justified, with its upper bytes zero.
- R9: When `swap_en` is 1, bus byte j and bus byte 7-j trade places, both for write data leaving the unit and for read data entering it.
- R10: A doubleword written in one mode and read back at the same address after a mode switch returns the same value, as long as `swap_en` is unchanged.
- R11: A valid request whose address is not a multiple of its size raises `misalign_err` and drives `bus_valid` low and `bus_be` to zero. With `req_valid` low, `bus_valid`, `bus_be` and `misalign_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_set | input | 1 | Load the mode register at this edge |
| mode_le_in | input | 1 | New mode: 1 little-endian, 0 big-endian |
| swap_en | input | 1 | Static enable for the full 8-byte bus swap |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Effective address |
| req_size | input | 3 | Size code: 0 byte, 1 half, 2 word, 3 doubleword, 4 vector |
| req_walk | input | 1 | Page/hash table walk, never munged |
| req_wdata | input | 64 | Right-justified write operand |
| bus_rdata | input | 64 | Read beat from the bus |
| bus_valid | output | 1 | Bus access issued |
| bus_addr | output | 32 | Munged bus address |
| bus_be | output | 8 | Byte enables, bit j covers bits 8j+7:8j |
| bus_wdata | output | 64 | Lane-placed write data |
| rd_data | output | 64 | Right-justified read result |
| misalign_err | output | 1 | Request not naturally aligned |

## Verification
The bench sweeps every operand size over all eight low address offsets. It does this for each combination of mode, walk flag and swap enable. Misaligned offsets are separated from aligned ones, and the XOR constant, byte enables and data lanes are checked for each case. Comparing the walk-flag runs with the plain runs shows that the exemption overrides the mode. The swap runs show that the reversal touches data but never addresses or enables. Further sequences check when a mode write takes effect, a doubleword round trip across a mode change, and a word written in little-endian mode and read back one byte at a time. Together these show that byte-level ordering really turns around.

// File: rtl/endian_pkg.sv
package endian_pkg;
  typedef enum logic [2:0] {
    SZ_BYTE  = 3'd0,
    SZ_HALF  = 3'd1,
    SZ_WORD  = 3'd2,
    SZ_DWORD = 3'd3,
    SZ_VEC   = 3'd4
  } opsize_e;
endpackage

// File: rtl/endian_mode_reg.sv
module endian_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic set_le,
  output logic le_q
);
  logic le_d;

  always_comb begin
    le_d = le_q;
    if (set_en) le_d = set_le;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) le_q <= 1'b0;
    else        le_q <= le_d;
  end

  // mode only moves on a write request
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en |=> $stable(le_q));
endmodule

// File: rtl/endian_addr_xform.sv
module endian_addr_xform #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 3,
  parameter int LG_W   = 2
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic [2:0]        size,
  input  logic              munge_en,
  output logic [ADDR_W-1:0] ma,
  output logic [LG_W-1:0]   size_lg,
  output logic              misaligned
);
  localparam int CW = OFF_W + 1;
  logic [OFF_W-1:0] low_mask;
  logic [OFF_W-1:0] flip;

  always_comb begin
    if (size >= 3'(OFF_W)) size_lg = LG_W'(OFF_W);
    else                   size_lg = LG_W'(size);
    low_mask   = OFF_W'((CW'(1) << size_lg) - CW'(1));
    flip       = munge_en ? ~low_mask : '0;
    misaligned = |(ea[OFF_W-1:0] & low_mask);
    ma         = {ea[ADDR_W-1:OFF_W], ea[OFF_W-1:0] ^ flip};
  end
endmodule

// File: rtl/endian_bus_swap.sv
module endian_bus_swap #(
  parameter int BYTES = 8
) (
  input  logic               en,
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);
  logic [8*BYTES-1:0] rev;

  for (genvar j = 0; j < BYTES; j++) begin : g_rev
    assign rev[8*j +: 8] = din[8*(BYTES-1-j) +: 8];
  end

  assign dout = en ? rev : din;
endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer #(
  parameter int BYTES = 8,
  parameter int OFF_W = 3,
  parameter int LG_W  = 2
) (
  input  logic               active,
  input  logic [OFF_W-1:0]   off,
  input  logic [LG_W-1:0]    size_lg,
  input  logic [8*BYTES-1:0] wdata,
  input  logic [8*BYTES-1:0] rlanes,
  output logic [BYTES-1:0]   be,
  output logic [8*BYTES-1:0] wlanes,
  output logic [8*BYTES-1:0] rdata
);
  localparam int CW = OFF_W + 1;
  logic [CW-1:0]      n_b, off_x, sh_b;
  logic [8*BYTES-1:0] opmask;

  always_comb begin
    off_x = {1'b0, off};
    n_b   = CW'(1) << size_lg;
    sh_b  = CW'(BYTES) - n_b - off_x;
  end

  for (genvar k = 0; k < BYTES; k++) begin : g_mask
    assign opmask[8*k +: 8] = (CW'(k) < n_b) ? 8'hFF : 8'h00;
  end

  for (genvar j = 0; j < BYTES; j++) begin : g_be
    localparam int LANE = BYTES - 1 - j;
    assign be[j] = active && (CW'(LANE) >= off_x) && (CW'(LANE) < off_x + n_b);
  end

  always_comb begin
    wlanes = active ? ((wdata & opmask) << {sh_b, 3'b000}) : '0;
    rdata  = active ? ((rlanes >> {sh_b, 3'b000}) & opmask) : '0;
  end
endmodule

// File: rtl/endian_munge_unit.sv
module endian_munge_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_set,
  input  logic              mode_le_in,
  input  logic              swap_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic              req_walk,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              misalign_err
);
  import endian_pkg::*;

  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam int LG_W  = $clog2(OFF_W + 1);

  logic              le_mode, munge_en, misaligned, active;
  logic [ADDR_W-1:0] ma;
  logic [LG_W-1:0]   size_lg;
  logic [DATA_W-1:0] wlanes, rlanes;

  endian_mode_reg i_mode (
    .clk(clk), .rst_n(rst_n), .set_en(mode_set), .set_le(mode_le_in), .le_q(le_mode)
  );

  assign munge_en = le_mode && !req_walk;

  endian_addr_xform #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LG_W(LG_W)) i_xform (
    .ea(req_addr), .size(req_size), .munge_en(munge_en),
    .ma(ma), .size_lg(size_lg), .misaligned(misaligned)
  );

  assign active       = req_valid && !misaligned;
  assign bus_valid    = active;
  assign misalign_err = req_valid && misaligned;
  assign bus_addr     = ma;

  endian_bus_swap #(.BYTES(BYTES)) i_rswap (
    .en(swap_en), .din(bus_rdata), .dout(rlanes)
  );

  endian_lane_steer #(.BYTES(BYTES), .OFF_W(OFF_W), .LG_W(LG_W)) i_steer (
    .active(active), .off(ma[OFF_W-1:0]), .size_lg(size_lg), .wdata(req_wdata),
    .rlanes(rlanes), .be(bus_be), .wlanes(wlanes), .rdata(rd_data)
  );

  endian_bus_swap #(.BYTES(BYTES)) i_wswap (
    .en(swap_en), .din(wlanes), .dout(bus_wdata)
  );

  p_upper_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[ADDR_W-1:OFF_W] == req_addr[ADDR_W-1:OFF_W]);

  p_walk_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && req_walk) |-> bus_addr == req_addr);

  p_wide_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && req_size >= SZ_DWORD) |-> bus_addr == req_addr);

  p_be_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $countones(bus_be) == ((req_size >= SZ_DWORD) ? BYTES : (1 << req_size)));

  p_err_no_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> (!bus_valid && bus_be == '0));
endmodule

// File: tb/test_endian_munge_unit.sv
module test_endian_munge_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_set, mode_le_in, swap_en, req_valid, req_walk;
  logic [31:0] req_addr;
  logic [2:0]  req_size;
  logic [63:0] req_wdata, bus_rdata;
  logic        bus_valid, misalign_err;
  logic [31:0] bus_addr;
  logic [7:0]  bus_be;
  logic [63:0] bus_wdata, rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  endian_munge_unit i_endian_munge_unit (
    .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_le_in(mode_le_in),
    .swap_en(swap_en), .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_walk(req_walk), .req_wdata(req_wdata), .bus_rdata(bus_rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .misalign_err(misalign_err)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [2:0] s);
    return (s >= 3) ? 8 : (1 << s);
  endfunction

  function automatic logic [63:0] bswap(input logic [63:0] d);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(7-i) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] opmask(input int n);
    return (n == 8) ? '1 : ((64'd1 << (8*n)) - 64'd1);
  endfunction

  task automatic set_mode(input logic le);
    @(negedge clk);
    mode_set = 1'b1; mode_le_in = le;
    @(posedge clk);
    #1 mode_set = 1'b0;
  endtask

  task automatic issue(input logic [31:0] a, input logic [2:0] s, input logic w,
                       input logic [63:0] wd, input logic [63:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = s; req_walk = w;
    req_wdata = wd; bus_rdata = rd;
    #1;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual %h expected %h", 64'd0, 64'd1);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] stored;
    rst_n = 1'b0; mode_set = 1'b0; mode_le_in = 1'b0; swap_en = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_size = '0; req_walk = 1'b0;
    req_wdata = '0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 idle outputs
    #1;
    check(!bus_valid && bus_be == 8'h00 && !misalign_err, "R11 idle",
          {bus_valid, bus_be, misalign_err}, 64'd0);

    // R1 reset is big-endian for every size
    for (int s = 0; s < 5; s++) begin
      issue(32'h0000_1000, 3'(s), 1'b0, '0, '0);
      check(bus_addr == 32'h0000_1000, "R1 reset big-endian", bus_addr, 32'h0000_1000);
    end

    // R3 mode change timing
    issue(32'h0000_2000, 3'd0, 1'b0, '0, '0);
    mode_set = 1'b1; mode_le_in = 1'b1;
    #1 check(bus_addr == 32'h0000_2000, "R3 before edge", bus_addr, 32'h0000_2000);
    @(posedge clk); #1;
    mode_set = 1'b0; mode_le_in = 1'b0;
    check(bus_addr == 32'h0000_2007, "R3 after edge", bus_addr, 32'h0000_2007);
    @(posedge clk); #1;
    check(bus_addr == 32'h0000_2007, "R3 hold", bus_addr, 32'h0000_2007);

    // exhaustive sweep of mode, swap, walk, size, offset
    for (int le = 0; le < 2; le++) begin
      set_mode(le[0]);
      for (int sw = 0; sw < 2; sw++) begin
        swap_en = sw[0];
        for (int wk = 0; wk < 2; wk++) begin
          for (int s = 0; s < 5; s++) begin
            for (int off = 0; off < 8; off++) begin
              int n, mo, sh;
              bit al;
              logic [31:0] ea, ea_exp;
              logic [7:0]  be_exp;
              logic [63:0] wd, rd, w_exp, r_exp;
              string atag;
              n  = nbytes(3'(s));
              al = (off % n) == 0;
              mo = (le == 1 && wk == 0) ? (off ^ (7 & ~(n - 1))) : off;
              ea = 32'hABCD_0010 | 32'(off);
              ea_exp = 32'hABCD_0010 | 32'(mo);
              wd = 64'h0123_4567_89AB_CDEF ^ (64'(off) * 64'h1111_1111);
              rd = 64'hF0E1_D2C3_B4A5_9687 ^ (64'(s) << 20);
              sh = 8 - n - mo;
              be_exp = '0;
              for (int i = mo; i < mo + n; i++) if (i < 8) be_exp[7-i] = 1'b1;
              w_exp = (wd & opmask(n)) << (8*sh);
              if (sw == 1) w_exp = bswap(w_exp);
              r_exp = (((sw == 1) ? bswap(rd) : rd) >> (8*sh)) & opmask(n);
              atag = (wk == 1) ? "R4 walk address" : ((s == 4) ? "R5 vector address" : "R2 address");
              issue(ea, 3'(s), wk[0], wd, rd);
              check(misalign_err == !al && bus_valid == al, "R11 alignment",
                    {misalign_err, bus_valid}, {62'd0, !al, al});
              if (al) begin
                check(bus_addr == ea_exp, atag, bus_addr, ea_exp);
                check(bus_be == be_exp, "R6 byte enables", bus_be, be_exp);
                check(bus_wdata == w_exp, (sw == 1) ? "R9 swapped write" : "R7 write lanes",
                      bus_wdata, w_exp);
                check(rd_data == r_exp, (sw == 1) ? "R9 swapped read" : "R8 read extract",
                      rd_data, r_exp);
              end else begin
                check(bus_be == 8'h00, "R11 no enables", bus_be, 64'd0);
              end
            end
          end
        end
      end
    end

    // R10 doubleword round trip across a mode switch, both swap settings
    for (int sw = 0; sw < 2; sw++) begin
      swap_en = sw[0];
      set_mode(1'b0);
      issue(32'h0000_0040, 3'd3, 1'b0, 64'h1122_3344_5566_7788, '0);
      stored = bus_wdata;
      set_mode(1'b1);
      issue(32'h0000_0040, 3'd3, 1'b0, '0, stored);
      check(rd_data == 64'h1122_3344_5566_7788, "R10 round trip", rd_data,
            64'h1122_3344_5566_7788);
    end

    // R2 little-endian view: word written, low byte read at the same address
    swap_en = 1'b0;
    issue(32'h0000_0080, 3'd2, 1'b0, 64'h0000_0000_A1B2_C3D4, '0);
    stored = bus_wdata;
    issue(32'h0000_0080, 3'd0, 1'b0, '0, stored);
    check(rd_data == 64'h0000_0000_0000_00D4, "R2 little-endian byte view", rd_data, 64'hD4);
    issue(32'h0000_0083, 3'd0, 1'b0, '0, stored);
    check(rd_data == 64'h0000_0000_0000_00A1, "R2 little-endian top byte", rd_data, 64'hA1);

    @(negedge clk);
    req_valid = 1'b0;
    #1 check(!bus_valid && bus_be == 8'h00 && !misalign_err, "R11 idle again",
             {bus_valid, bus_be, misalign_err}, 64'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule